// File: doc/BRIEF.md
# Read/Write Head Mode Controller

This block sits between the configuration registers and the analog front end of a multi-head disk preamplifier. Each clock it samples a 2-bit power-mode field, a 4-bit head code, a register bit that chooses between the live head and the dummy head, the read/write pin, the servo-write pin and a write-kill line raised by the fault logic. From these it works out one operating state: sleep, standby, active read or active write. It then drives registered enable vectors for the twelve readers and twelve writers, together with the dummy-head select, the write-current enable, the MR bias enable, the fault-detector enable, a high-impedance flag for the read outputs and an illegal-head flag.

Write current has several guards. It is never on in read. It cannot start when the write request arrives straight from sleep or standby. Once a fault has stopped it, it stays off until the read/write pin has been seen high and then low again. In the servo-write two-head arrangement, a write drives a head and its partner six positions higher, while a read still uses one head only.

Top module: `head_mode_ctrl`

## Requirements
- R1: While rstN is low and after its release, the block is in sleep: every enable is 0, rdHiZ is 1, faultDetEn is 0, dummySel and badHead are 0.
- R2: pwrMode 2'b00 gives sleep (rdHiZ=1, mrBiasEn=0, faultDetEn=0, no heads). pwrMode 2'b01 gives standby (the same, except faultDetEn=1). pwrMode 2'b10 and 2'b11 are active.
- R3: In active mode with rwSel=1 (read), the block gives rdEnable=1<<headCode, mrBiasEn=1, rdHiZ=0, wrCurEn=0 and wrEnable=0.
- R4: In active mode with rwSel=0, starting from read, the block gives wrCurEn=1, wrEnable=1<<headCode, rdEnable=0 and mrBiasEn=1.
- R5: rwSel=0 sampled while the state is sleep or standby sets a write lock. Write current stays off through the move to active until rwSel has been sampled high and then low again.
- R6: wrKill=1 sets the write lock. wrCurEn and wrEnable are 0 one clock later, and they stay 0 after wrKill falls, until rwSel has been sampled high and then low again.
- R7: headCode 12 to 15 is illegal. In read it gives dummySel=1 and rdEnable=0. In write it gives wrCurEn=0 and wrEnable=0. badHead=1 in both active states and 0 in sleep and standby.
- R8: liveHeadOn=0 in read gives dummySel=1 and rdEnable=0. It has no effect in write, where dummySel=0.
- R9: With pwrMode=2'b11 and servoWrLow=0, let x be headCode mod 6. Read enables bit x only. Write enables bits x and x+6.
- R10: With pwrMode=2'b11 and servoWrLow=1, the block acts as single-head active mode, the same as under R3 and R4.
- R11: Every output takes the value implied by the inputs sampled at a rising edge, one clock after that edge. The state changes at most once per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrMode | input | 2 | Power mode field: 00 sleep, 01 standby, 10 active, 11 test/two-head |
| headCode | input | 4 | Selected head number, 0 to 11 legal |
| liveHeadOn | input | 1 | 1 = selected head used in read, 0 = dummy head |
| rwSel | input | 1 | 1 = read, 0 = write |
| servoWrLow | input | 1 | 0 = servo-write arrangement |
| wrKill | input | 1 | Fault request to stop write current |
| rdEnable | output | 12 | Per-head reader enable |
| wrEnable | output | 12 | Per-head writer enable |
| dummySel | output | 1 | Reader steered to dummy head |
| wrCurEn | output | 1 | Write current source enable |
| mrBiasEn | output | 1 | MR bias source enable |
| faultDetEn | output | 1 | Fault detectors powered |
| rdHiZ | output | 1 | Read outputs high-impedance |
| badHead | output | 1 | Illegal head code fault |

## Verification
The bench targets the ways a write can start when it must not. One case is a write request that comes in during sleep or standby, where a design without the lock would drive current as soon as the mode turns active. The other is a fault that clears while rwSel stays low, where a lock that drops with the fault would restart the writer too soon. It drives codes 12 to 15 in both directions, where a missing range check would enable no reader or a phantom writer. It also drives pair mode with codes above 5, where wrong folding would pick the wrong partner or enable a second reader. A model in the bench runs beside the design and is compared on every clock, so an extra cycle of delay or a skipped state shows up at once.

// File: rtl/head_mode_pkg.sv
package head_mode_pkg;

  typedef enum logic [1:0] {
    OP_SLEEP = 2'd0,
    OP_STBY  = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } opState_t;

  localparam logic [1:0] MODE_SLEEP = 2'b00;
  localparam logic [1:0] MODE_STBY  = 2'b01;
  localparam logic [1:0] MODE_PAIR  = 2'b11;

  // Strobes from control to datapath: next-cycle intent
  typedef struct packed {
    logic readArm;
    logic writeArm;
    logic biasOn;
    logic outHiZ;
    logic faultOn;
    logic pairMode;
  } ctrlStrobe_t;

endpackage

// File: rtl/head_mode_fsm.sv
module head_mode_fsm
  import head_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  pwrMode,
  input  logic        rwSel,
  input  logic        servoWrLow,
  input  logic        wrKill,
  output ctrlStrobe_t strobe
);

  opState_t opState, nextState;
  logic     wrLock, nextLock;
  logic     isIdle;

  assign isIdle = (opState == OP_SLEEP) || (opState == OP_STBY);

  always_comb begin
    case (pwrMode)
      MODE_SLEEP: nextState = OP_SLEEP;
      MODE_STBY:  nextState = OP_STBY;
      default:    nextState = rwSel ? OP_READ : OP_WRITE;
    endcase
  end

  // Lock sets on a fault or a write request from idle; clears only when rwSel is seen high
  always_comb begin
    nextLock = wrKill || (!rwSel && isIdle) || (wrLock && !rwSel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opState <= OP_SLEEP;
      wrLock  <= 1'b0;
    end else begin
      opState <= nextState;
      wrLock  <= nextLock;
    end
  end

  always_comb begin
    strobe.readArm  = (nextState == OP_READ);
    strobe.writeArm = (nextState == OP_WRITE) && !nextLock;
    strobe.biasOn   = (nextState == OP_READ) || (nextState == OP_WRITE);
    strobe.outHiZ   = (nextState == OP_SLEEP) || (nextState == OP_STBY);
    strobe.faultOn  = (nextState != OP_SLEEP);
    strobe.pairMode = (pwrMode == MODE_PAIR) && !servoWrLow;
  end

  AST_IDLE_WRITE_LOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (isIdle && !rwSel) |=> wrLock); // R5

  AST_LOCK_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (wrLock && !rwSel) |=> wrLock); // R6

  AST_KILL_LOCKS: assert property (@(posedge clk) disable iff (!rstN)
    wrKill |=> wrLock); // R6

endmodule

// File: rtl/head_enable_path.sv
module head_enable_path
  import head_mode_pkg::*;
#(
  parameter int NUM_HEADS = 12,
  parameter int CODE_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [CODE_W-1:0]    headCode,
  input  logic                 liveHeadOn,
  output logic [NUM_HEADS-1:0] rdEnable,
  output logic [NUM_HEADS-1:0] wrEnable,
  output logic                 dummySel,
  output logic                 wrCurEn,
  output logic                 mrBiasEn,
  output logic                 faultDetEn,
  output logic                 rdHiZ,
  output logic                 badHead
);

  localparam int                PAIR_SPAN = NUM_HEADS / 2;
  localparam logic [CODE_W-1:0] PAIR_OFS  = CODE_W'(PAIR_SPAN);
  localparam logic [CODE_W-1:0] CODE_LIM  = CODE_W'(NUM_HEADS);

  logic                 illegal;
  logic [CODE_W-1:0]    pairIdx, pairHi, rdIdx;
  logic                 useDummy, writeOn;
  logic [NUM_HEADS-1:0] rdNext, wrNext;

  assign illegal  = (headCode >= CODE_LIM);
  assign pairIdx  = (headCode >= PAIR_OFS) ? headCode - PAIR_OFS : headCode;
  assign pairHi   = pairIdx + PAIR_OFS;
  assign rdIdx    = strobe.pairMode ? pairIdx : headCode;
  assign useDummy = strobe.readArm && (illegal || !liveHeadOn);
  assign writeOn  = strobe.writeArm && !illegal;

  for (genvar h = 0; h < NUM_HEADS; h++) begin : g_head
    localparam logic [CODE_W-1:0] HID = CODE_W'(h);
    assign rdNext[h] = strobe.readArm && !useDummy && (rdIdx == HID);
    assign wrNext[h] = writeOn && (strobe.pairMode ? ((pairIdx == HID) || (pairHi == HID))
                                                   : (headCode == HID));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdEnable   <= '0;
      wrEnable   <= '0;
      dummySel   <= 1'b0;
      wrCurEn    <= 1'b0;
      mrBiasEn   <= 1'b0;
      faultDetEn <= 1'b0;
      rdHiZ      <= 1'b1;
      badHead    <= 1'b0;
    end else begin
      rdEnable   <= rdNext;
      wrEnable   <= wrNext;
      dummySel   <= useDummy;
      wrCurEn    <= writeOn;
      mrBiasEn   <= strobe.biasOn;
      faultDetEn <= strobe.faultOn;
      rdHiZ      <= strobe.outHiZ;
      badHead    <= illegal && strobe.biasOn;
    end
  end

  AST_READ_EXCLUDES_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (|rdEnable) |-> (!wrCurEn && wrEnable == '0)); // R3

  AST_SINGLE_READER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rdEnable)); // R3

  AST_NO_CURRENT_NO_WRITER: assert property (@(posedge clk) disable iff (!rstN)
    !wrCurEn |-> (wrEnable == '0)); // R4

  AST_WRITER_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    wrCurEn |-> ($countones(wrEnable) == 1 || $countones(wrEnable) == 2)); // R9

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    badHead |-> (!wrCurEn && wrEnable == '0 && rdEnable == '0)); // R7

  AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    rdHiZ |-> (!mrBiasEn && !wrCurEn && rdEnable == '0 && !badHead)); // R2

  AST_DUMMY_NO_READER: assert property (@(posedge clk) disable iff (!rstN)
    dummySel |-> (rdEnable == '0)); // R8

endmodule

// File: rtl/head_mode_ctrl.sv
module head_mode_ctrl
  import head_mode_pkg::*;
#(
  parameter int NUM_HEADS = 12,
  parameter int CODE_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           pwrMode,
  input  logic [CODE_W-1:0]    headCode,
  input  logic                 liveHeadOn,
  input  logic                 rwSel,
  input  logic                 servoWrLow,
  input  logic                 wrKill,
  output logic [NUM_HEADS-1:0] rdEnable,
  output logic [NUM_HEADS-1:0] wrEnable,
  output logic                 dummySel,
  output logic                 wrCurEn,
  output logic                 mrBiasEn,
  output logic                 faultDetEn,
  output logic                 rdHiZ,
  output logic                 badHead
);

  ctrlStrobe_t strobe;

  head_mode_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .pwrMode    (pwrMode),
    .rwSel      (rwSel),
    .servoWrLow (servoWrLow),
    .wrKill     (wrKill),
    .strobe     (strobe)
  );

  head_enable_path #(
    .NUM_HEADS (NUM_HEADS),
    .CODE_W    (CODE_W)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .headCode   (headCode),
    .liveHeadOn (liveHeadOn),
    .rdEnable   (rdEnable),
    .wrEnable   (wrEnable),
    .dummySel   (dummySel),
    .wrCurEn    (wrCurEn),
    .mrBiasEn   (mrBiasEn),
    .faultDetEn (faultDetEn),
    .rdHiZ      (rdHiZ),
    .badHead    (badHead)
  );

endmodule

// File: tb/tb_head_mode_ctrl.sv
module tb_head_mode_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  pwrMode = 2'b00;
  logic [3:0]  headCode = 4'd0;
  logic        liveHeadOn = 1'b1;
  logic        rwSel = 1'b1;
  logic        servoWrLow = 1'b1;
  logic        wrKill = 1'b0;
  logic [11:0] rdEnable, wrEnable;
  logic        dummySel, wrCurEn, mrBiasEn, faultDetEn, rdHiZ, badHead;

  always #5 clk = ~clk;

  head_mode_ctrl dut (
    .clk(clk), .rstN(rstN), .pwrMode(pwrMode), .headCode(headCode),
    .liveHeadOn(liveHeadOn), .rwSel(rwSel), .servoWrLow(servoWrLow), .wrKill(wrKill),
    .rdEnable(rdEnable), .wrEnable(wrEnable), .dummySel(dummySel), .wrCurEn(wrCurEn),
    .mrBiasEn(mrBiasEn), .faultDetEn(faultDetEn), .rdHiZ(rdHiZ), .badHead(badHead)
  );

  int    tests = 0;
  int    fails = 0;
  bit    chkOn = 1'b0;
  bit    done  = 1'b0;
  string curReq = "R1";

  // Behavioural reference: state 0 sleep, 1 standby, 2 read, 3 write
  int          mSt = 0;
  bit          mLock = 1'b0;
  logic [11:0] eRd = '0, eWr = '0;
  bit          eDum = 0, eCur = 0, eBias = 0, eFdet = 0, eHiz = 1, eBad = 0;

  always @(posedge clk) begin
    int  nSt, code, x;
    bit  nLock, bad, pair, rd, wr;
    if (!rstN) begin
      mSt = 0; mLock = 0;
      eRd = '0; eWr = '0; eDum = 0; eCur = 0; eBias = 0; eFdet = 0; eHiz = 1; eBad = 0;
    end else begin
      code = int'(headCode);
      if (pwrMode == 2'b00) nSt = 0;
      else if (pwrMode == 2'b01) nSt = 1;
      else nSt = rwSel ? 2 : 3;
      nLock = wrKill || (!rwSel && mSt < 2) || (mLock && !rwSel);
      bad  = code >= 12;
      pair = (pwrMode == 2'b11) && !servoWrLow;
      x    = code % 6;
      rd   = (nSt == 2);
      wr   = (nSt == 3) && !nLock && !bad;
      eDum = rd && (bad || !liveHeadOn);
      eRd  = (rd && !eDum) ? 12'(1 << (pair ? x : code)) : 12'd0;
      eWr  = wr ? (pair ? 12'((1 << x) | (1 << (x + 6))) : 12'(1 << code)) : 12'd0;
      eCur = wr;
      eBias = nSt >= 2;
      eHiz  = nSt < 2;
      eFdet = nSt != 0;
      eBad  = bad && nSt >= 2;
      mSt = nSt; mLock = nLock;
    end
  end

  // R11: compared every cycle, one clock after the sampling edge
  always @(negedge clk) begin
    if (chkOn && !done) begin
      tests++;
      if (rdEnable !== eRd || wrEnable !== eWr || dummySel !== eDum || wrCurEn !== eCur ||
          mrBiasEn !== eBias || faultDetEn !== eFdet || rdHiZ !== eHiz || badHead !== eBad) begin
        fails++;
        $display("FAIL %s t=%0t got rd=%h wr=%h dum=%b cur=%b bias=%b fdet=%b hiz=%b bad=%b exp rd=%h wr=%h dum=%b cur=%b bias=%b fdet=%b hiz=%b bad=%b",
                 curReq, $time, rdEnable, wrEnable, dummySel, wrCurEn, mrBiasEn, faultDetEn, rdHiZ, badHead,
                 eRd, eWr, eDum, eCur, eBias, eFdet, eHiz, eBad);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(posedge clk);
    chkOn = 1'b1;
    curReq = "R1"; step(3);
    rstN = 1'b1; step(3);

    curReq = "R2"; pwrMode = 2'b00; step(2);
    pwrMode = 2'b01; step(3);
    pwrMode = 2'b00; step(2);

    curReq = "R3"; pwrMode = 2'b10; rwSel = 1'b1;
    for (int c = 0; c < 12; c++) begin headCode = 4'(c); step(1); end
    step(2);

    curReq = "R4"; headCode = 4'd4; rwSel = 1'b0; step(3);
    headCode = 4'd11; step(2);
    headCode = 4'd0; step(2);
    rwSel = 1'b1; step(2);

    curReq = "R5"; pwrMode = 2'b00; step(2);
    rwSel = 1'b0; step(2);
    pwrMode = 2'b10; step(4);
    rwSel = 1'b1; step(2);
    rwSel = 1'b0; step(3);
    rwSel = 1'b1; pwrMode = 2'b01; step(2);
    rwSel = 1'b0; step(1);
    pwrMode = 2'b10; step(3);
    rwSel = 1'b1; step(1);
    rwSel = 1'b0; step(2);

    curReq = "R6"; headCode = 4'd7; wrKill = 1'b1; step(1);
    wrKill = 1'b0; step(4);
    rwSel = 1'b1; wrKill = 1'b1; step(1);
    wrKill = 1'b0; step(1);
    rwSel = 1'b0; step(1);
    rwSel = 1'b1; step(1);
    rwSel = 1'b0; step(3);
    rwSel = 1'b1; step(1);

    curReq = "R7";
    for (int c = 12; c < 16; c++) begin headCode = 4'(c); step(1); end
    rwSel = 1'b0; headCode = 4'd3; step(1);
    for (int c = 12; c < 16; c++) begin headCode = 4'(c); step(1); end
    headCode = 4'd3; step(2);
    pwrMode = 2'b01; headCode = 4'd13; step(2);
    pwrMode = 2'b00; step(2);
    rwSel = 1'b1; headCode = 4'd2; pwrMode = 2'b10; step(2);

    curReq = "R8"; liveHeadOn = 1'b0; step(2);
    rwSel = 1'b0; step(2);
    rwSel = 1'b1; step(1);
    liveHeadOn = 1'b1; step(2);

    curReq = "R9"; pwrMode = 2'b11; servoWrLow = 1'b0;
    foreach (eRd[i]) begin headCode = 4'(i); step(1); end
    rwSel = 1'b0;
    for (int c = 0; c < 16; c++) begin headCode = 4'(c); step(1); end
    rwSel = 1'b1; step(1);

    curReq = "R10"; servoWrLow = 1'b1; headCode = 4'd8; step(2);
    rwSel = 1'b0; step(3);
    headCode = 4'd1; step(2);
    rwSel = 1'b1; step(2);

    curReq = "R11"; pwrMode = 2'b00; step(1);
    pwrMode = 2'b10; step(1);
    rwSel = 1'b0; step(1);
    rwSel = 1'b1; step(1);
    pwrMode = 2'b01; step(2);

    curReq = "R1"; rstN = 1'b0; step(3);
    rstN = 1'b1; step(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule